// File: doc/BRIEF.md
# 8b/10b Code Group Decoder with Running-Disparity Check

This block turns word-aligned 10-bit code groups into an 8-bit value and a control flag. Two error flags are produced with them: one for any pattern outside the code table and one for a running-disparity violation. All four results leave the block through a single register stage, so each flag sits on the same output cycle as the byte decoded from the offending code group.

The running disparity starts in an undetermined state after reset. The first unbalanced code group accepted after reset fixes its polarity, and that code group is never flagged. Code groups offered before the word-aligned input has been seen high since reset are dropped: they produce no output and teach the disparity tracker nothing.

Bit order on the 10-bit input: bit 0 carries a, bits 1..5 carry b, c, d, e, i, bit 6 carries f and bits 7..9 carry g, h, j.

Top module: `dec8b10b`

## Requirements
- R1: While `rst_i` is high, every output is cleared to zero, the running disparity returns to the undetermined state and the alignment history is cleared.
- R2: A code group is accepted only when `valid_i` is high and `aligned_i` is high in that cycle or has been high in some cycle since reset. A code group that is not accepted produces no `valid_o` and does not change the running disparity.
- R3: `valid_o` is high exactly one cycle after an accepted code group, and it is low otherwise.
- R4: Each of the 256 data values, encoded in either disparity column, decodes to its byte `{HGF,EDCBA}` with `k_o`, `code_err_o` and `disp_err_o` all low.
- R5: The 12 control codes (K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7) decode with `k_o` high. K28.5 is 10'h17C in the RD- column and 10'h283 in the RD+ column, and both forms decode to 8'hBC.
- R6: While the running disparity is undetermined, no disparity error is flagged. Neutral code groups (five ones) leave it undetermined. The first accepted code group with six ones sets it positive, and the first with four ones sets it negative.
- R7: With negative running disparity, an accepted code group with fewer than five ones raises `disp_err_o`. With positive running disparity, one with more than five ones raises it.
- R8: Each accepted code group updates the running disparity from its own ones count, whether or not its pattern is in the table: six ones makes it positive, four ones makes it negative, and any other count leaves it unchanged.
- R9: A pattern that is not a valid data or control code in either column raises `code_err_o`. For such a pattern `data_o` is 8'h00 and `k_o` is low.
- R10: When `disp_err_o` is high, `code_err_o` is also high. A valid pattern received with the wrong disparity still returns its decoded byte and control flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| code_i | input | 10 | Code group, bit 0 = a, bit 9 = j |
| valid_i | input | 1 | A code group is present on `code_i` |
| aligned_i | input | 1 | Word alignment achieved |
| valid_o | output | 1 | Decoded result is valid |
| data_o | output | 8 | Decoded byte |
| k_o | output | 1 | Control code flag |
| code_err_o | output | 1 | Invalid pattern or disparity error |
| disp_err_o | output | 1 | Running-disparity violation |

## Verification
Some rules are checked by the assertions on every cycle:
- the reset clearing of the tracker (R1);
- the polarity the tracker takes after six-one and four-one code groups, and that it holds after other counts (R8);
- that `valid_o` never appears without an accepted input, or before alignment (R2, R3);
- that a disparity error always carries a code error (R10);
- that a control flag only appears with a legal control byte (R5).

Other behaviour only the bench scenarios can show: the full mapping of every data and control code in both columns, how the first polarity is learned after a neutral code group, and that input dropped before alignment teaches the tracker nothing. The injected invalid and wrong-disparity patterns likewise show the data-zeroing and both flags together.

// File: rtl/dec8b10b_pkg.sv
package dec8b10b_pkg;
  localparam int SYM_W  = 10;
  localparam int SUB6_W = 6;
  localparam int SUB4_W = 4;
  localparam int BYTE_W = 8;
  localparam int ONES_W = $clog2(SYM_W + 1);

  // reverse a sub-block written with its first transmitted bit leftmost
  function automatic logic [SUB6_W-1:0] flip6(input logic [SUB6_W-1:0] v);
    logic [SUB6_W-1:0] r;
    for (int i = 0; i < SUB6_W; i++) r[i] = v[SUB6_W-1-i];
    return r;
  endfunction

  function automatic logic [SUB4_W-1:0] flip4(input logic [SUB4_W-1:0] v);
    logic [SUB4_W-1:0] r;
    for (int i = 0; i < SUB4_W; i++) r[i] = v[SUB4_W-1-i];
    return r;
  endfunction

  // 5b->6b, negative-disparity column, written abcdei
  function automatic logic [5:0] tab6(input logic [4:0] x);
    case (x)
      5'd0:  return 6'b100111;  5'd1:  return 6'b011101;
      5'd2:  return 6'b101101;  5'd3:  return 6'b110001;
      5'd4:  return 6'b110101;  5'd5:  return 6'b101001;
      5'd6:  return 6'b011001;  5'd7:  return 6'b111000;
      5'd8:  return 6'b111001;  5'd9:  return 6'b100101;
      5'd10: return 6'b010101;  5'd11: return 6'b110100;
      5'd12: return 6'b001101;  5'd13: return 6'b101100;
      5'd14: return 6'b011100;  5'd15: return 6'b010111;
      5'd16: return 6'b011011;  5'd17: return 6'b100011;
      5'd18: return 6'b010011;  5'd19: return 6'b110010;
      5'd20: return 6'b001011;  5'd21: return 6'b101010;
      5'd22: return 6'b011010;  5'd23: return 6'b111010;
      5'd24: return 6'b110011;  5'd25: return 6'b100110;
      5'd26: return 6'b010110;  5'd27: return 6'b110110;
      5'd28: return 6'b001110;  5'd29: return 6'b101110;
      5'd30: return 6'b011110;  default: return 6'b101011;
    endcase
  endfunction

  // 3b->4b data, negative-disparity column, primary .7, written fghj
  function automatic logic [3:0] tab4(input logic [2:0] y);
    case (y)
      3'd0: return 4'b1011;  3'd1: return 4'b1001;
      3'd2: return 4'b0101;  3'd3: return 4'b1100;
      3'd4: return 4'b1101;  3'd5: return 4'b1010;
      3'd6: return 4'b0110;  default: return 4'b1110;
    endcase
  endfunction

  // 4b part of K28.y when the whole group is in the negative column
  function automatic logic [3:0] k28tab4(input logic [2:0] y);
    case (y)
      3'd0: return 4'b0100;  3'd1: return 4'b1001;
      3'd2: return 4'b0101;  3'd3: return 4'b0011;
      3'd4: return 4'b0010;  3'd5: return 4'b1010;
      3'd6: return 4'b0110;  default: return 4'b1000;
    endcase
  endfunction

  // encode one byte from the given running disparity (1 = positive)
  function automatic logic [SYM_W-1:0] encode(input logic [7:0] d, input logic k,
                                              input logic rdp);
    logic [4:0] x;
    logic [2:0] y;
    logic [5:0] s6;
    logic [3:0] s4;
    logic       mid;
    logic       alt;
    logic [SYM_W-1:0] full;
    x = d[4:0];
    y = d[7:5];
    if (k && x == 5'd28) begin
      full = {flip4(k28tab4(y)), flip6(6'b001111)};
      return rdp ? ~full : full;
    end
    s6 = tab6(x);
    if (x == 5'd7) s6 = rdp ? 6'b000111 : 6'b111000;
    else if ($countones(s6) != 3 && rdp) s6 = ~s6;
    mid = ($countones(s6) == 3) ? rdp : ~rdp;
    alt = k || (!mid && (x == 5'd17 || x == 5'd18 || x == 5'd20))
            || (mid && (x == 5'd11 || x == 5'd13 || x == 5'd14));
    if (y == 3'd7) begin
      if (alt) s4 = mid ? 4'b1000 : 4'b0111;
      else     s4 = mid ? 4'b0001 : 4'b1110;
    end else begin
      s4 = tab4(y);
      if (y == 3'd3) s4 = mid ? 4'b0011 : 4'b1100;
      else if ($countones(s4) != 2 && mid) s4 = ~s4;
    end
    return {flip4(s4), flip6(s6)};
  endfunction
endpackage

// File: rtl/dec8b10b_sub6.sv
module dec8b10b_sub6
  import dec8b10b_pkg::*;
(
  input  logic [SUB6_W-1:0] sub_i,
  output logic [4:0]        x_o,
  output logic              k28_o,
  output logic              k28_pos_o,
  output logic              hit_o
);
  localparam logic [SUB6_W-1:0] K28_NEG = flip6(6'b001111);
  localparam logic [SUB6_W-1:0] K28_POS = flip6(6'b110000);
  localparam logic [SUB6_W-1:0] D7_NEG  = flip6(6'b111000);
  localparam logic [SUB6_W-1:0] D7_POS  = flip6(6'b000111);
  localparam int                N_SYM   = 32;

  always_comb begin
    logic [SUB6_W-1:0] p;
    logic              m;
    x_o       = '0;
    hit_o     = 1'b0;
    k28_pos_o = (sub_i == K28_POS);
    k28_o     = (sub_i == K28_NEG) || k28_pos_o;
    if (k28_o) begin
      x_o   = 5'd28;
      hit_o = 1'b1;
    end
    for (int i = 0; i < N_SYM; i++) begin
      p = flip6(tab6(5'(i)));
      if (i == 7)                 m = (sub_i == D7_NEG) || (sub_i == D7_POS);
      else if ($countones(p) != 3) m = (sub_i == p) || (sub_i == ~p);
      else                        m = (sub_i == p);
      if (m && !hit_o) begin
        x_o   = 5'(i);
        hit_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dec8b10b_sub4.sv
module dec8b10b_sub4
  import dec8b10b_pkg::*;
(
  input  logic [SUB4_W-1:0] sub_i,
  input  logic              inv_i,
  output logic [2:0]        y_o,
  output logic              alt7_o,
  output logic              hit_o
);
  localparam logic [SUB4_W-1:0] A7_NEG = flip4(4'b0111);
  localparam logic [SUB4_W-1:0] A7_POS = flip4(4'b1000);
  localparam logic [SUB4_W-1:0] Y3_POS = flip4(4'b0011);
  localparam int                N_SYM  = 8;

  always_comb begin
    logic [SUB4_W-1:0] s;
    logic [SUB4_W-1:0] p;
    logic              m;
    s      = inv_i ? ~sub_i : sub_i;
    y_o    = '0;
    hit_o  = 1'b0;
    alt7_o = (s == A7_NEG) || (s == A7_POS);
    if (alt7_o) begin
      y_o   = 3'd7;
      hit_o = 1'b1;
    end
    for (int i = 0; i < N_SYM; i++) begin
      p = flip4(tab4(3'(i)));
      if (i == 3)                  m = (s == p) || (s == Y3_POS);
      else if ($countones(p) != 2) m = (s == p) || (s == ~p);
      else                         m = (s == p);
      if (m && !hit_o) begin
        y_o   = 3'(i);
        hit_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dec8b10b_check.sv
module dec8b10b_check
  import dec8b10b_pkg::*;
(
  input  logic [SYM_W-1:0]  code_i,
  input  logic [4:0]        x_i,
  input  logic [2:0]        y_i,
  input  logic              k28_i,
  input  logic              alt7_i,
  input  logic              hit6_i,
  input  logic              hit4_i,
  output logic              ok_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              k_o,
  output logic [ONES_W-1:0] ones_o
);
  logic [BYTE_W-1:0] cand;
  logic              kc;

  always_comb begin
    cand   = {y_i, x_i};
    kc     = k28_i || (alt7_i && (x_i == 5'd23 || x_i == 5'd27 ||
                                  x_i == 5'd29 || x_i == 5'd30));
    ok_o   = hit6_i && hit4_i &&
             ((code_i == encode(cand, kc, 1'b0)) || (code_i == encode(cand, kc, 1'b1)));
    byte_o = ok_o ? cand : '0;
    k_o    = ok_o && kc;
    ones_o = ONES_W'($countones(code_i));
  end

  // R9: a pattern accepted as valid has a neutral or singly unbalanced weight
  always_comb begin
    if (ok_o) begin
      a_ok_weight_r9: assert (ones_o >= ONES_W'(4) && ones_o <= ONES_W'(6));
    end
  end
endmodule

// File: rtl/dec8b10b_rd.sv
module dec8b10b_rd
  import dec8b10b_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              accept_i,
  input  logic [ONES_W-1:0] ones_i,
  output logic              disp_err_o
);
  localparam logic [ONES_W-1:0] HALF = ONES_W'(SYM_W / 2);

  logic known_q;
  logic pos_q;

  always_comb
    disp_err_o = known_q && (pos_q ? (ones_i > HALF) : (ones_i < HALF));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      known_q <= 1'b0;
      pos_q   <= 1'b0;
    end else if (accept_i) begin
      if (ones_i == HALF + 1'b1) begin
        known_q <= 1'b1;
        pos_q   <= 1'b1;
      end else if (ones_i == HALF - 1'b1) begin
        known_q <= 1'b1;
        pos_q   <= 1'b0;
      end
    end
  end

  p_clear_r1: assert property (@(posedge clk_i) rst_i |=> !known_q);
  p_to_pos_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (accept_i && ones_i == ONES_W'(6)) |=> (known_q && pos_q));
  p_to_neg_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (accept_i && ones_i == ONES_W'(4)) |=> (known_q && !pos_q));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (!accept_i || (ones_i != ONES_W'(4) && ones_i != ONES_W'(6))) |=> $stable({known_q, pos_q}));
endmodule

// File: rtl/dec8b10b.sv
module dec8b10b
  import dec8b10b_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic [SYM_W-1:0]      code_i,
  input  logic                  valid_i,
  input  logic                  aligned_i,
  output logic                  valid_o,
  output logic [BYTE_W-1:0]     data_o,
  output logic                  k_o,
  output logic                  code_err_o,
  output logic                  disp_err_o
);
  logic              align_q;
  logic              accept;
  logic [4:0]        x;
  logic [2:0]        y;
  logic              k28, k28_pos, alt7, hit6, hit4;
  logic              ok;
  logic [BYTE_W-1:0] byte_d;
  logic              k_d;
  logic [ONES_W-1:0] ones;
  logic              disp_d;

  assign accept = valid_i && (align_q || aligned_i);

  dec8b10b_sub6 u_sub6 (
    .sub_i     (code_i[SUB6_W-1:0]),
    .x_o       (x),
    .k28_o     (k28),
    .k28_pos_o (k28_pos),
    .hit_o     (hit6)
  );

  dec8b10b_sub4 u_sub4 (
    .sub_i  (code_i[SYM_W-1:SUB6_W]),
    .inv_i  (k28_pos),
    .y_o    (y),
    .alt7_o (alt7),
    .hit_o  (hit4)
  );

  dec8b10b_check u_check (
    .code_i (code_i),
    .x_i    (x),
    .y_i    (y),
    .k28_i  (k28),
    .alt7_i (alt7),
    .hit6_i (hit6),
    .hit4_i (hit4),
    .ok_o   (ok),
    .byte_o (byte_d),
    .k_o    (k_d),
    .ones_o (ones)
  );

  dec8b10b_rd u_rd (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .accept_i   (accept),
    .ones_i     (ones),
    .disp_err_o (disp_d)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      align_q    <= 1'b0;
      valid_o    <= 1'b0;
      data_o     <= '0;
      k_o        <= 1'b0;
      code_err_o <= 1'b0;
      disp_err_o <= 1'b0;
    end else begin
      if (aligned_i) align_q <= 1'b1;
      valid_o <= accept;
      if (accept) begin
        data_o     <= byte_d;
        k_o        <= k_d;
        disp_err_o <= disp_d;
        code_err_o <= !ok || disp_d;
      end
    end
  end

  p_reset_r1: assert property (@(posedge clk_i) rst_i |=> (!valid_o && !code_err_o && !disp_err_o));
  p_follow_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |-> $past(valid_i));
  p_noalign_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!align_q && !aligned_i) |=> !valid_o);
  p_disp_err_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    disp_err_o |-> code_err_o);
  p_k_legal_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_o && k_o) |-> (data_o[4:0] == 5'd28 || data_o[7:5] == 3'd7));
endmodule

// File: tb/test_dec8b10b.sv
module test_dec8b10b;
  localparam int CLK_P = 10;
  localparam int WDOG  = 20000;

  logic       clk = 1'b0;
  logic       rst;
  logic [9:0] code;
  logic       vin, aligned;
  logic       vout;
  logic [7:0] dout;
  logic       kout, cerr, derr;
  int         n_chk = 0;
  int         n_fail = 0;
  logic       brd;

  always #(CLK_P/2) clk = ~clk;

  dec8b10b i_dec8b10b (
    .clk_i(clk), .rst_i(rst), .code_i(code), .valid_i(vin), .aligned_i(aligned),
    .valid_o(vout), .data_o(dout), .k_o(kout), .code_err_o(cerr), .disp_err_o(derr)
  );

  // reference sub-blocks, written in transmit order (a..i, f..j)
  function automatic logic [5:0] r6(input int x);
    logic [5:0] t [32];
    t = '{6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001, 6'b011001, 6'b111000,
          6'b111001, 6'b100101, 6'b010101, 6'b110100, 6'b001101, 6'b101100, 6'b011100, 6'b010111,
          6'b011011, 6'b100011, 6'b010011, 6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010,
          6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110, 6'b011110, 6'b101011};
    return t[x];
  endfunction

  function automatic logic [3:0] r4(input int y);
    logic [3:0] t [8];
    t = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};
    return t[y];
  endfunction

  function automatic logic [9:0] pack(input logic [5:0] s6, input logic [3:0] s4);
    logic [9:0] c;
    for (int i = 0; i < 6; i++) c[i] = s6[5-i];
    for (int i = 0; i < 4; i++) c[6+i] = s4[3-i];
    return c;
  endfunction

  function automatic logic [9:0] ref_enc(input int v, input bit k, input bit rdp);
    int x, y;
    logic [5:0] s6;
    logic [3:0] s4;
    bit mid;
    logic [3:0] kt [8];
    x = v % 32;
    y = v / 32;
    if (k && x == 28) begin
      kt = '{4'b0100, 4'b1001, 4'b0101, 4'b0011, 4'b0010, 4'b1010, 4'b0110, 4'b1000};
      return rdp ? ~pack(6'b001111, kt[y]) : pack(6'b001111, kt[y]);
    end
    s6 = r6(x);
    if (x == 7) begin
      s6  = rdp ? 6'b000111 : 6'b111000;
      mid = rdp;
    end else if ($countones(s6) == 3) begin
      mid = rdp;
    end else begin
      if (rdp) s6 = ~s6;
      mid = !rdp;
    end
    if (y == 7) begin
      if (k || (!mid && (x == 17 || x == 18 || x == 20)) || (mid && (x == 11 || x == 13 || x == 14)))
        s4 = mid ? 4'b1000 : 4'b0111;
      else
        s4 = mid ? 4'b0001 : 4'b1110;
    end else if (y == 3) begin
      s4 = mid ? 4'b0011 : 4'b1100;
    end else begin
      s4 = r4(y);
      if ($countones(s4) != 2 && mid) s4 = ~s4;
    end
    return pack(s6, s4);
  endfunction

  task automatic check(input string req, input logic ev, input logic [7:0] ed,
                       input logic ek, input logic ece, input logic ede);
    n_chk++;
    if (vout !== ev || (ev && (dout !== ed || kout !== ek || cerr !== ece || derr !== ede))) begin
      n_fail++;
      $display("FAIL %s: got v=%b d=%h k=%b ce=%b de=%b, expected v=%b d=%h k=%b ce=%b de=%b",
               req, vout, dout, kout, cerr, derr, ev, ed, ek, ece, ede);
    end
  endtask

  // drive one code group, wait for the registered result, check it
  task automatic send(input logic [9:0] c, input string req, input logic ev, input logic [7:0] ed,
                      input logic ek, input logic ece, input logic ede);
    code = c;
    vin  = 1'b1;
    @(negedge clk);
    vin  = 1'b0;
    check(req, ev, ed, ek, ece, ede);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    vin = 1'b0;
    aligned = 1'b0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (vout !== 1'b0 || dout !== 8'h00 || kout !== 1'b0 || cerr !== 1'b0 || derr !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: reset outputs v=%b d=%h k=%b ce=%b de=%b, expected all zero",
               vout, dout, kout, cerr, derr);
    end
    rst = 1'b0;
  endtask

  task automatic sweep(input bit start_pos);
    logic [9:0] c;
    int kv [12];
    kv = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC, 8'hF7, 8'hFB, 8'hFD, 8'hFE};
    do_reset();
    aligned = 1'b1;
    brd = start_pos;
    for (int i = 0; i < 256; i++) begin
      c = ref_enc(start_pos ? 255 - i : i, 1'b0, brd);
      send(c, "R4 data", 1'b1, 8'(start_pos ? 255 - i : i), 1'b0, 1'b0, 1'b0);
      if ($countones(c) == 6) brd = 1'b1; else if ($countones(c) == 4) brd = 1'b0;
    end
    for (int i = 0; i < 12; i++) begin
      c = ref_enc(kv[i], 1'b1, brd);
      send(c, "R5 control", 1'b1, 8'(kv[i]), 1'b1, 1'b0, 1'b0);
      if ($countones(c) == 6) brd = 1'b1; else if ($countones(c) == 4) brd = 1'b0;
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    code = '0;
    // R2: dropped before alignment, and no disparity learned from it
    do_reset();
    send(10'h283, "R2 pre-align", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    send(10'h283, "R2 pre-align", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    aligned = 1'b1;
    send(10'h283, "R2 first after align", 1'b1, 8'hBC, 1'b1, 1'b0, 1'b0);
    aligned = 1'b0;
    send(10'h17C, "R2 alignment remembered", 1'b1, 8'hBC, 1'b1, 1'b0, 1'b0);
    // R3: idle cycle gives no valid output
    @(negedge clk);
    check("R3 idle", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);

    // R6: neutral first code leaves disparity undetermined
    do_reset();
    aligned = 1'b1;
    send(ref_enc(8'h23, 1'b0, 1'b0), "R6 neutral first", 1'b1, 8'h23, 1'b0, 1'b0, 1'b0);
    send(10'h283, "R6 learn negative", 1'b1, 8'hBC, 1'b1, 1'b0, 1'b0);
    send(10'h283, "R7 negative violated", 1'b1, 8'hBC, 1'b1, 1'b1, 1'b1);
    // R6/R7 positive side; R10 data kept under disparity error
    do_reset();
    aligned = 1'b1;
    send(10'h17C, "R6 learn positive", 1'b1, 8'hBC, 1'b1, 1'b0, 1'b0);
    send(10'h17C, "R7 R10 positive violated", 1'b1, 8'hBC, 1'b1, 1'b1, 1'b1);
    send(10'h283, "R5 K28.5 RD+ form", 1'b1, 8'hBC, 1'b1, 1'b0, 1'b0);

    // R8/R9: invalid patterns still move the running disparity by weight
    send(10'h3C3, "R9 invalid six ones", 1'b1, 8'h00, 1'b0, 1'b1, 1'b0);
    send(10'h3C3, "R8 invalid set positive", 1'b1, 8'h00, 1'b0, 1'b1, 1'b1);
    send(10'h007, "R9 invalid three ones", 1'b1, 8'h00, 1'b0, 1'b1, 1'b0);
    send(10'h3C3, "R8 three ones kept positive", 1'b1, 8'h00, 1'b0, 1'b1, 1'b1);
    send(10'h0FF, "R8 eight ones", 1'b1, 8'h00, 1'b0, 1'b1, 1'b1);
    send(10'h283, "R8 still positive before", 1'b1, 8'hBC, 1'b1, 1'b0, 1'b0);
    send(10'h007, "R7 negative low weight", 1'b1, 8'h00, 1'b0, 1'b1, 1'b1);

    // R4/R5: full sweeps from both starting polarities
    sweep(1'b0);
    sweep(1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule